// File: doc/BRIEF.md
# Write-Through Direct-Mapped Word Cache

This block places a small direct-mapped cache between a processor port and a slower, word-addressed memory port. It holds one data word per entry. Each word address is split into a low index field, which picks exactly one entry, and a tag built from the remaining upper address bits. A lookup that finds a valid entry with a matching tag is served from the cache. A lookup that fails stalls the processor while a single memory read brings the word in.

Stores are written through: every store, hit or miss, produces a memory write. A store that misses first fetches the word into its entry, then merges the store data into it. Only one request is in flight at a time. The processor holds its read or write strobe, address and data until a one-cycle `cpu_ready` pulse. If both strobes are high, the request is treated as a store. Two counters record the outcome of each lookup so that a reference model can compare the hit/miss sequence.

Top module: `wt_dm_cache`

## Requirements
- R1: The default configuration has 8 entries of one 32-bit word and an 8-bit word address; the entry index is `cpu_addr[2:0]` and the tag is `cpu_addr[7:3]`.
- R2: While `rst_n` is low, and after it rises, all entries are invalid, `cpu_ready` and `mem_req` are low and both counters are zero, so the first lookup of any index misses.
- R3: A read that hits returns the cached word with `cpu_ready` high on the second rising edge after the strobe is sampled, and it causes no memory traffic.
- R4: A read that misses issues exactly one memory read of the same address, fills the entry with the returned word and returns that word.
- R5: A store that hits updates the entry and issues exactly one memory write of the store data to the same address, with no memory read.
- R6: A store that misses issues one memory read and then one memory write, and leaves the stored word in the entry, so a later read of that address hits and returns it.
- R7: A lookup with a matching index but a different tag replaces the old entry; for example, addresses 22 and 6 evict each other.
- R8: `cpu_ready` is low from the sampled strobe until completion and is a single-cycle pulse; `cpu_ready` and `mem_req` are never high together.
- R9: `mem_req` is held with stable `mem_addr` and `mem_we` until `mem_ack`, and acknowledges may take any number of cycles.
- R10: Every lookup adds one to exactly one counter (`hit_count` on a hit, `miss_count` on a miss); refills are not counted again.
- R11: If memory acknowledges L cycles after `mem_req` is first seen, a read miss completes in 4+L cycles, a store hit in 4+L cycles and a store miss in 6+2L cycles (cycles counted from the strobe-sampling edge to the edge that raises `cpu_ready`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_rd | input | 1 | Processor read strobe, held until `cpu_ready` |
| cpu_wr | input | 1 | Processor store strobe, held until `cpu_ready` |
| cpu_addr | input | 8 | Processor word address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Read result, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | High for a memory write, low for a read |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle memory acknowledge |
| hit_count | output | 16 | Number of lookups that hit |
| miss_count | output | 16 | Number of lookups that missed |

## Verification
A corrupted valid bit or tag appears within one request. It shows as a wrong step in `hit_count` or `miss_count`, an unexpected memory read, and a completion time that differs from the hit or miss figure. A corrupted data word appears as a wrong `cpu_rdata` on the next read hit of that address. Because the cache never differs from memory under write-through, the expected read value is always the current memory word.

A state machine that skips the fetch or the write-through shows up at completion of the same request, as a missing memory read or write and a shorter cycle count. The sweeps vary the acknowledge latency, so timing errors tied to the handshake also appear in the cycle count.

// File: rtl/wt_dm_cache_pkg.sv
// Package: shared types for the write-through direct-mapped cache.
// Assumes: nothing beyond IEEE 1800-2017.
package wt_dm_cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_FETCH,
        ST_WRITE_MEM,
        ST_DONE
    } ctrl_state_t;
endpackage

// File: rtl/wt_dm_store.sv
// Module: entry storage with a valid bit, a tag and one data word per entry.
// Lookup is combinational on lk_idx; the one write port fills or updates an
// entry and marks it valid. Assumes ENTRIES is a power of two.
module wt_dm_store #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3,
    parameter int TAG_W   = 5,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_valid,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic              valid_q [ENTRIES];
    logic [TAG_W-1:0]  tag_q   [ENTRIES];
    logic [DATA_W-1:0] data_q  [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        // Valid bit: cleared by reset, set when the entry is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid_q[e] <= 1'b0;
            else if (wr_en && wr_idx == IDX_W'(e))
                valid_q[e] <= 1'b1;
        end

        // Tag and data: loaded on a write to this entry.
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(e)) begin
                tag_q[e]  <= wr_tag;
                data_q[e] <= wr_data;
            end
        end

        AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> !valid_q[e]); // R2
        AST_FILL_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(e)) |=> (valid_q[e] && tag_q[e] == $past(wr_tag))); // R7
    end

    // Lookup port: the entry selected by the index.
    always_comb begin
        lk_valid = valid_q[lk_idx];
        lk_tag   = tag_q[lk_idx];
        lk_data  = data_q[lk_idx];
    end
endmodule

// File: rtl/wt_dm_fsm.sv
// Module: request sequencer. It latches one processor request, compares its
// tag, fetches on a miss, writes every store through and pulses cpu_ready.
// Assumes the processor holds its strobes until cpu_ready and that memory
// gives a one-cycle mem_ack with read data valid in that cycle.
module wt_dm_fsm
    import wt_dm_cache_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic              lk_valid,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [DATA_W-1:0] lk_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data,
    output logic              hit_pulse,
    output logic              miss_pulse
);
    ctrl_state_t       state_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic              req_wr_q;
    logic [DATA_W-1:0] rdata_q;
    logic              wt_done_q;
    logic              is_hit;

    assign lk_idx = req_addr_q[IDX_W-1:0];
    assign is_hit = lk_valid && (lk_tag == req_addr_q[ADDR_W-1:IDX_W]);

    // State register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            req_wr_q    <= 1'b0;
            rdata_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (cpu_rd || cpu_wr) begin
                    req_addr_q  <= cpu_addr;
                    req_wdata_q <= cpu_wdata;
                    req_wr_q    <= cpu_wr;
                    state_q     <= ST_COMPARE;
                end
                ST_COMPARE: begin
                    if (!is_hit)
                        state_q <= ST_FETCH;
                    else if (req_wr_q)
                        state_q <= ST_WRITE_MEM;
                    else begin
                        rdata_q <= lk_data;
                        state_q <= ST_DONE;
                    end
                end
                ST_FETCH: if (mem_ack) begin
                    if (!req_wr_q)
                        rdata_q <= mem_rdata;
                    state_q <= req_wr_q ? ST_WRITE_MEM : ST_DONE;
                end
                ST_WRITE_MEM: if (mem_ack)
                    state_q <= ST_DONE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Records that the current store has reached memory (checked at completion).
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE)
            wt_done_q <= 1'b0;
        else if (state_q == ST_WRITE_MEM && mem_ack)
            wt_done_q <= 1'b1;
    end

    // Entry write: store hit update, or refill merged with store data.
    always_comb begin
        wr_idx  = req_addr_q[IDX_W-1:0];
        wr_tag  = req_addr_q[ADDR_W-1:IDX_W];
        wr_en   = 1'b0;
        wr_data = req_wdata_q;
        if (state_q == ST_COMPARE && is_hit && req_wr_q)
            wr_en = 1'b1;
        else if (state_q == ST_FETCH && mem_ack) begin
            wr_en   = 1'b1;
            wr_data = req_wr_q ? req_wdata_q : mem_rdata;
        end
    end

    // Port outputs driven from the state.
    always_comb begin
        mem_req    = (state_q == ST_FETCH) || (state_q == ST_WRITE_MEM);
        mem_we     = (state_q == ST_WRITE_MEM);
        mem_addr   = req_addr_q;
        mem_wdata  = req_wdata_q;
        cpu_ready  = (state_q == ST_DONE);
        cpu_rdata  = rdata_q;
        hit_pulse  = (state_q == ST_COMPARE) && is_hit;
        miss_pulse = (state_q == ST_COMPARE) && !is_hit;
    end

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R8
    AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req); // R8
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9
    AST_STORE_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && req_wr_q) |-> wt_done_q); // R5
endmodule

// File: rtl/wt_dm_stats.sv
// Module: lookup outcome counters, one event per lookup.
// Assumes hit and miss pulses are one cycle wide; the counters wrap.
module wt_dm_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_pulse,
    input  logic             miss_pulse,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    // Count hits and misses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            if (hit_pulse)  hit_count  <= hit_count + 1'b1;
            if (miss_pulse) miss_count <= miss_count + 1'b1;
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_pulse, miss_pulse})); // R10
endmodule

// File: rtl/wt_dm_cache.sv
// Module: top of the write-through direct-mapped word cache. It connects the
// sequencer, the entry store and the counters. Assumes ADDR_W > log2(ENTRIES).
module wt_dm_cache #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 8,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  lk_idx;
    logic              lk_valid;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] lk_data;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;
    logic              hit_pulse;
    logic              miss_pulse;

    wt_dm_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
        .hit_pulse(hit_pulse), .miss_pulse(miss_pulse)
    );

    wt_dm_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data)
    );

    wt_dm_stats #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst_n(rst_n),
        .hit_pulse(hit_pulse), .miss_pulse(miss_pulse),
        .hit_count(hit_count), .miss_count(miss_count)
    );
endmodule

// File: tb/tb_wt_dm_cache.sv
// Bench: drives requests from tasks, models memory with adjustable ack
// latency, and predicts each outcome from a reference model of the entries.
module tb_wt_dm_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [15:0] hit_count, miss_count;

    always #10 clk = ~clk; // 50 MHz

    wt_dm_cache dut (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .hit_count(hit_count), .miss_count(miss_count)
    );

    int vectors = 0, miscompares = 0, cycles = 0;
    bit finished = 1'b0;

    // Memory model and its traffic counters.
    logic [31:0] mem [256];
    int lat = 0, lat_cnt = 0, mem_reads = 0, mem_writes = 0;
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            if (lat_cnt >= lat) begin
                mem_ack <= 1'b1;
                lat_cnt <= 0;
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata;
                    mem_writes <= mem_writes + 1;
                end else begin
                    mem_rdata <= mem[mem_addr];
                    mem_reads <= mem_reads + 1;
                end
            end else
                lat_cnt <= lat_cnt + 1;
        end else
            mem_ack <= 1'b0;
    end

    // Reference state: expected memory contents and entry valid/tag.
    logic [31:0] shadow [256];
    bit          rv   [8];
    logic [4:0]  rtag [8];

    function automatic logic [31:0] init_word(int a);
        return (32'(a) * 32'h01010101) ^ 32'hA5000000;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "watchdog", 32'(cycles), 32'd150000);
            finish_run();
        end
    end

    task automatic ref_clear();
        for (int i = 0; i < 8; i++) begin rv[i] = 1'b0; rtag[i] = '0; end
    endtask

    // One processor request with full outcome checking.
    task automatic do_op(bit is_wr, logic [7:0] a, logic [31:0] wd, int l);
        int idx = int'(a[2:0]);
        bit exp_hit = rv[idx] && rtag[idx] == a[7:3];
        int exp_cyc, n = 0;
        int h0, m0, r0, w0;
        @(negedge clk);
        lat = l;
        h0 = int'(hit_count); m0 = int'(miss_count); r0 = mem_reads; w0 = mem_writes;
        exp_cyc = !is_wr ? (exp_hit ? 2 : 4 + l) : (exp_hit ? 4 + l : 6 + 2 * l);
        cpu_rd = !is_wr; cpu_wr = is_wr; cpu_addr = a; cpu_wdata = wd;
        do begin
            @(posedge clk); @(negedge clk); n++;
        end while (!cpu_ready && n < 200);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        if (is_wr) shadow[a] = wd;
        rv[idx] = 1'b1; rtag[idx] = a[7:3];
        chk(n == exp_cyc, "R11 completion cycles", 32'(n), 32'(exp_cyc));
        chk(int'(hit_count) == h0 + (exp_hit ? 1 : 0), "R10 hit count", 32'(hit_count), 32'(h0 + (exp_hit ? 1 : 0)));
        chk(int'(miss_count) == m0 + (exp_hit ? 0 : 1), "R7 miss count", 32'(miss_count), 32'(m0 + (exp_hit ? 0 : 1)));
        chk(mem_reads == r0 + (exp_hit ? 0 : 1), is_wr ? "R6 memory reads" : "R4 memory reads", 32'(mem_reads), 32'(r0 + (exp_hit ? 0 : 1)));
        chk(mem_writes == w0 + (is_wr ? 1 : 0), is_wr ? "R5 memory writes" : "R3 memory writes", 32'(mem_writes), 32'(w0 + (is_wr ? 1 : 0)));
        if (!is_wr)
            chk(cpu_rdata == shadow[a], exp_hit ? "R3 read data" : "R4 read data", cpu_rdata, shadow[a]);
        else
            chk(mem[a] == wd, "R5 memory word", mem[a], wd);
        @(negedge clk);
        chk(!cpu_ready, "R8 ready pulse", 32'(cpu_ready), 32'd0);
    endtask

    task automatic apply_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!cpu_ready && !mem_req, "R2 idle outputs in reset", {30'd0, cpu_ready, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hit_count == 0 && miss_count == 0, "R2 counters cleared", {hit_count, miss_count}, 32'd0);
        ref_clear();
    endtask

    initial begin
        logic [31:0] lcg = 32'h1234_5678;
        for (int i = 0; i < 256; i++) begin mem[i] = init_word(i); shadow[i] = init_word(i); end
        ref_clear();
        apply_reset();
        // R7 and R1: the classic conflict sequence on index 110/010/000.
        do_op(0, 8'd22, 0, 0); do_op(0, 8'd26, 0, 0); do_op(0, 8'd22, 0, 1);
        do_op(0, 8'd26, 0, 2); do_op(0, 8'd16, 0, 0); do_op(0, 8'd3, 0, 3);
        do_op(0, 8'd16, 0, 0); do_op(0, 8'd18, 0, 1);
        do_op(0, 8'd6, 0, 0);  do_op(0, 8'd22, 0, 0); do_op(0, 8'd6, 0, 2);
        // R2: a reset in mid-run empties the cache again.
        apply_reset();
        do_op(0, 8'd16, 0, 0);
        // R1: read sweeps across all index/tag pairs of a 64-word window.
        for (int p = 0; p < 2; p++)
            for (int a = 0; a < 64; a++) do_op(0, 8'(a), 0, a % 4);
        for (int a = 56; a < 64; a++) do_op(0, 8'(a), 0, 0);
        // R5/R6: store hits and store misses, then read back.
        for (int a = 56; a < 64; a++) do_op(1, 8'(a), 32'hC0DE_0000 + 32'(a), a % 3);
        for (int a = 0; a < 8; a++)   do_op(1, 8'(a + 128), 32'hBEEF_0000 + 32'(a), a % 4);
        for (int a = 0; a < 8; a++)   do_op(0, 8'(a + 128), 0, 0);
        for (int a = 56; a < 64; a++) do_op(0, 8'(a), 0, 1);
        // Mixed traffic over the full address space.
        for (int k = 0; k < 400; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            do_op(lcg[31], lcg[13] ? lcg[23:16] : {5'd0, lcg[18:16]}, lcg ^ 32'h5A5A_A5A5, int'(lcg[9:8]));
        end
        finish_run();
    end
endmodule